// File: doc/BRIEF.md
# Debounced Matrix Keypad Encoder

This block turns the raw row and column lines of a 4x4 matrix keypad into a clean key event: a 4-bit key number plus a level flag that says a key is down. It looks at the lines only on a slow sample tick, which it makes itself from the system clock through a cycle counter. It takes a key as pressed only when exactly one row and one column are asserted, and only when that same pattern appears on two samples in a row. It takes a key as released only after two samples in a row show no legal press. Contact bounce and row and column lines that close at different moments are therefore filtered out.

The output is a one-way stream with no ready input. A keypad cannot be held off, so there is no back-pressure. A consumer treats the rising edge of the flag as one key event and reads the number at any cycle while the flag stays high. The block has no reset pin. Every register it holds, including unused state codes, settles to the released condition within two sample periods of power-up when no key is pressed. The sample spacing comes from two parameters, the clock rate in kHz and the interval in microseconds, so it can be tuned to the bounce time of the switches.

Top module: `keypad_matrix_encoder`

## Requirements
- R1: While `key_valid_o` is high, `key_code_o` equals row index times 4 plus column index of the pressed key, where bit i of `row_i` or `col_i` is index i. Row 0 / column 0 gives 0, row 2 / column 0 gives 8, and row 3 / column 3 gives 15.
- R2: A sample is a press only if exactly one bit of `row_i` and exactly one bit of `col_i` are 1. Any other pattern, such as two rows, a row with no column, or nothing at all, counts as released.
- R3: Inputs are looked at once every CLK_KHZ*SAMPLE_US/1000 clock cycles, and at least every 2 cycles. A change that begins and ends between two sample points is never seen.
- R4: `key_valid_o` rises only after two consecutive samples show the same legal press. It therefore stays low for at least one full sample period after a press begins.
- R5: The key code is latched when `key_valid_o` rises and stays constant while it is high. A different legal key that appears without a stable release in between is ignored.
- R6: `key_valid_o` falls only after two consecutive samples both count as released. A release that is seen on only one sample leaves the flag and the code unchanged.
- R7: There is no reset input. From any power-up contents, with no key pressed, `key_valid_o` is low within two sample periods.
- R8: Inputs that alternate on every sample never produce two equal samples in a row, so `key_valid_o` does not change state while they alternate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| row_i | input | 4 | Row lines, active high, one-hot when a single key is down |
| col_i | input | 4 | Column lines, active high, one-hot when a single key is down |
| key_code_o | output | 4 | Binary number of the accepted key, held while valid |
| key_valid_o | output | 1 | High while a debounced legal key is held |

## Verification
The bench drives presses whose contacts bounce at exactly the sample rate. A filter that compared the wrong pair of samples would let these through, or drop the check entirely, and the flag would rise. It checks that the flag is still low one sample period after a clean press begins, which catches a design that accepts a key on its first sample. It slides from one key to another without a release, and it opens a key for a single sample. A design that did not latch the code would change the key number under a high flag, and one that debounced only presses would drop the flag on the brief opening. It also holds two rows, or a row with no column, and it checks the corner codes 0, 8 and 15, which catch a legality check that is too loose and a row/column weighting that is swapped.

// File: rtl/kpd_pkg.sv
package kpd_pkg;
  localparam int KP_ROWS   = 4;
  localparam int KP_COLS   = 4;
  localparam int KP_KEYS   = KP_ROWS * KP_COLS;
  localparam int KP_CODE_W = $clog2(KP_KEYS);

  typedef struct packed {
    logic                 pressed;
    logic [KP_CODE_W-1:0] code;
  } kp_sample_t;

  typedef enum logic [1:0] {
    KS_RELEASED = 2'b00,
    KS_HELD     = 2'b01
  } kp_state_t;
endpackage

// File: rtl/kpd_tick_gen.sv
module kpd_tick_gen #(
  parameter int PERIOD = 100000
) (
  input  logic clk,
  output logic tick_o
);
  localparam int CW   = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam int LAST = PERIOD - 1;

  logic [CW-1:0] cnt;

  // The compare is >= so that a counter that powers up beyond its range
  // still wraps on the next cycle.
  assign tick_o = (cnt >= CW'(LAST));

  always_ff @(posedge clk) begin
    if (tick_o) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/kpd_matrix_decode.sv
module kpd_matrix_decode
  import kpd_pkg::*;
(
  input  logic [KP_ROWS-1:0] row_i,
  input  logic [KP_COLS-1:0] col_i,
  output kp_sample_t         sample_o
);
  int  r_idx;
  int  c_idx;
  logic legal;

  always_comb begin
    r_idx = 0;
    for (int r = 0; r < KP_ROWS; r++)
      if (row_i[r]) r_idx = r;
    c_idx = 0;
    for (int c = 0; c < KP_COLS; c++)
      if (col_i[c]) c_idx = c;
  end

  assign legal = $onehot(row_i) && $onehot(col_i);

  always_comb begin
    sample_o = '0;
    if (legal) begin
      sample_o.pressed = 1'b1;
      sample_o.code    = KP_CODE_W'(r_idx * KP_COLS + c_idx);
    end
  end
endmodule

// File: rtl/kpd_stable_filter.sv
module kpd_stable_filter
  import kpd_pkg::*;
(
  input  logic                 clk,
  input  logic                 tick_i,
  input  kp_sample_t           sample_i,
  output logic [KP_CODE_W-1:0] code_o,
  output logic                 valid_o
);
  kp_sample_t prev;
  kp_state_t  state;
  logic       repeat_seen;

  assign repeat_seen = (sample_i == prev);

  always_ff @(posedge clk) begin
    if (tick_i) begin
      prev <= sample_i;
      case (state)
        KS_RELEASED: begin
          if (repeat_seen && sample_i.pressed) begin
            state  <= KS_HELD;
            code_o <= sample_i.code;
          end
        end
        KS_HELD: begin
          if (repeat_seen && !sample_i.pressed) state <= KS_RELEASED;
        end
        default: state <= KS_RELEASED;
      endcase
    end else if (state != KS_HELD && state != KS_RELEASED) begin
      state <= KS_RELEASED;
    end
  end

  assign valid_o = (state == KS_HELD);
endmodule

// File: rtl/keypad_matrix_encoder.sv
module keypad_matrix_encoder
  import kpd_pkg::*;
#(
  parameter int CLK_KHZ   = 50000,
  parameter int SAMPLE_US = 2000
) (
  input  logic                 clk,
  input  logic [KP_ROWS-1:0]   row_i,
  input  logic [KP_COLS-1:0]   col_i,
  output logic [KP_CODE_W-1:0] key_code_o,
  output logic                 key_valid_o
);
  localparam int RAW_CYCLES  = (CLK_KHZ * SAMPLE_US) / 1000;
  localparam int TICK_CYCLES = (RAW_CYCLES < 2) ? 2 : RAW_CYCLES;

  logic       sample_tick;
  kp_sample_t cur_sample;

  kpd_tick_gen #(.PERIOD(TICK_CYCLES)) u_tick (
    .clk    (clk),
    .tick_o (sample_tick)
  );

  kpd_matrix_decode u_decode (
    .row_i    (row_i),
    .col_i    (col_i),
    .sample_o (cur_sample)
  );

  kpd_stable_filter u_filter (
    .clk      (clk),
    .tick_i   (sample_tick),
    .sample_i (cur_sample),
    .code_o   (key_code_o),
    .valid_o  (key_valid_o)
  );
endmodule

// File: rtl/kpd_checker.sv
module kpd_checker
  import kpd_pkg::*;
(
  input logic                 clk,
  input logic [KP_ROWS-1:0]   row_i,
  input logic [KP_COLS-1:0]   col_i,
  input logic [KP_CODE_W-1:0] key_code_o,
  input logic                 key_valid_o,
  input logic                 sample_tick
);
  logic [1:0] age = 2'd0;
  logic       warm;

  always_ff @(posedge clk)
    if (age != 2'd3) age <= age + 2'd1;

  assign warm = (age >= 2'd2);

  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!warm)
    (key_valid_o && $past(key_valid_o)) |-> $stable(key_code_o)); // R5

  AST_RISE_LEGAL: assert property (@(posedge clk) disable iff (!warm)
    $rose(key_valid_o) |-> $past($onehot(row_i) && $onehot(col_i))); // R2

  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!warm)
    $rose(key_valid_o) |-> $past(sample_tick)); // R4

  AST_FALL_ON_TICK: assert property (@(posedge clk) disable iff (!warm)
    $fell(key_valid_o) |-> $past(sample_tick)); // R6

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!warm)
    sample_tick |=> !sample_tick); // R3
endmodule

bind keypad_matrix_encoder kpd_checker u_chk (
  .clk         (clk),
  .row_i       (row_i),
  .col_i       (col_i),
  .key_code_o  (key_code_o),
  .key_valid_o (key_valid_o),
  .sample_tick (sample_tick)
);

// File: tb/keypad_matrix_encoder_test.sv
module keypad_matrix_encoder_test;
  localparam int P = 50; // cycles per sample with CLK_KHZ=50000, SAMPLE_US=1

  logic       clk = 1'b0;
  logic [3:0] row = '0;
  logic [3:0] col = '0;
  logic [3:0] code;
  logic       valid;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  keypad_matrix_encoder #(.CLK_KHZ(50000), .SAMPLE_US(1)) uut (
    .clk         (clk),
    .row_i       (row),
    .col_i       (col),
    .key_code_o  (code),
    .key_valid_o (valid)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic press(input int r, input int c);
    row = 4'(1 << r);
    col = 4'(1 << c);
  endtask

  task automatic release_keys();
    row = '0;
    col = '0;
  endtask

  task automatic t_powerup();
    wait_cyc(3 * P);
    check("R7 idle after power-up", {4'd0, valid}, 5'd0);
  endtask

  task automatic t_press_release(input int r, input int c, input string req);
    press(r, c);
    wait_cyc(P);
    check("R4 not valid after one period", {4'd0, valid}, 5'd0);
    wait_cyc(2 * P + 2);
    check({req, " valid after stable press"}, {4'd0, valid}, 5'd1);
    check({req, " key code"}, {1'b0, code}, 5'(r * 4 + c));
    release_keys();
    wait_cyc(P);
    check("R6 still valid one period after release", {4'd0, valid}, 5'd1);
    wait_cyc(2 * P + 2);
    check("R6 released", {4'd0, valid}, 5'd0);
  endtask

  task automatic t_glitch_and_slide();
    press(1, 1);
    wait_cyc(3 * P + 2);
    check("R1 code 5", {valid, code}, {1'b1, 4'd5});
    release_keys();
    wait_cyc(20);
    press(1, 1);
    wait_cyc(4 * P);
    check("R6 short opening ignored", {valid, code}, {1'b1, 4'd5});
    press(2, 3);
    wait_cyc(4 * P);
    check("R5 slide to other key ignored", {valid, code}, {1'b1, 4'd5});
    release_keys();
    wait_cyc(3 * P + 2);
    check("R6 release after slide", {4'd0, valid}, 5'd0);
  endtask

  task automatic t_illegal();
    row = 4'b0011; col = 4'b0001;
    wait_cyc(4 * P);
    check("R2 two rows ignored", {4'd0, valid}, 5'd0);
    row = 4'b0100; col = 4'b0000;
    wait_cyc(4 * P);
    check("R2 row without column ignored", {4'd0, valid}, 5'd0);
    row = 4'b0000; col = 4'b1001;
    wait_cyc(4 * P);
    check("R2 two columns no row ignored", {4'd0, valid}, 5'd0);
    release_keys();
    wait_cyc(3 * P);
  endtask

  task automatic t_bounce();
    logic seen = 1'b0;
    for (int i = 0; i < 12; i++) begin
      if (i % 2 == 0) press(3, 2); else release_keys();
      wait_cyc(P);
      if (valid) seen = 1'b1;
    end
    check("R8 alternating samples never accepted", {4'd0, seen}, 5'd0);
    check("R3 alternating at sample rate", {4'd0, valid}, 5'd0);
    release_keys();
    wait_cyc(3 * P);
  endtask

  initial begin
    wait_cyc(1);
    t_powerup();
    t_press_release(1, 2, "R1");
    t_press_release(3, 3, "R1");
    t_press_release(0, 0, "R1");
    t_press_release(2, 0, "R4");
    t_glitch_and_slide();
    t_illegal();
    t_bounce();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule